// File: doc/BRIEF.md
# Tile Fetch Flip Unit

This block sits between the video chip's pattern fetch bus and the cartridge pattern memory. It lets each background tile be mirrored on its own. When the video chip fetches a nametable entry, the block captures a 16-bit entry word. That word packs four fields: a 12-bit tile index, a 2-bit colour attribute, and two flip flags.

On the pattern plane fetches that follow, the block uses the captured entry in two ways:

- It builds the memory address. The tile index supplies the upper address bits. The row-within-tile bits are mirrored when vertical flip is set.
- It returns each pattern byte from memory, bit-reversed when horizontal flip is set.

The captured attribute is presented on a port of its own. The entry stays in force for both plane fetches of a tile. It is replaced only at the next nametable fetch strobe.

Bit positions within the entry word are:

| Bits | Field |
|------|-------|
| 11..0 | Tile index |
| 13..12 | Attribute |
| 14 | Horizontal flip |
| 15 | Vertical flip |

The memory address is formed as {tile[11:0], plane, row[2:0]}. The plane and row bits come from the low four bits of the fetch address.

Top module: `tf_flip_unit`

## Requirements
- R1: After reset the held entry is zero. Attribute reads 0, mem_addr reads {12'h000, vid_addr[3:0]}, and vid_rdata equals mem_rdata.
- R2: When nt_strobe is high at a rising clock edge, nt_word is captured. From the next cycle on, mem_addr[15:4] equals the captured nt_word[11:0].
- R3: While nt_strobe is low, changes on nt_word have no effect on mem_addr, attr or vid_rdata.
- R4: attr equals bits 13..12 of the held entry.
- R5: When bit 15 (vertical flip) of the held entry is 1, mem_addr[2:0] equals vid_addr[2:0] XOR 3'b111.
- R6: When bit 14 (horizontal flip) of the held entry is 1, vid_rdata[i] equals mem_rdata[7-i] for every bit i.
- R7: When both flip bits are 0, mem_addr[3:0] equals vid_addr[3:0] and vid_rdata equals mem_rdata.
- R8: mem_addr[3] (the plane select) always equals vid_addr[3], whatever the flip bits.
- R9: With both flip bits set, the row inversion and the bit reversal are applied together.
- R10: In the cycle in which nt_strobe is high, the outputs still follow the previously held entry. The new entry takes effect only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nt_strobe | input | 1 | Marks the nametable fetch; nt_word is captured at this edge |
| nt_word | input | 16 | Nametable entry presented during the nametable fetch |
| vid_addr | input | 4 | Low fetch address bits: [3] plane, [2:0] row |
| mem_rdata | input | 8 | Pattern byte read from memory |
| mem_addr | output | 16 | Rewritten pattern memory address |
| vid_rdata | output | 8 | Pattern byte returned to the video chip |
| attr | output | 2 | Colour attribute of the held entry |

## Verification
Entry capture and the address and data rewrite can fall in the same cycle. This happens when nt_strobe is raised while a pattern fetch for the previous tile is still on the bus. The bench provokes it by presenting a new entry with different flip flags together with a fetch address and data byte. It then checks that the outputs before the edge match the model of the old entry and the outputs after the edge match the new one. Random entries, addresses and bytes from a fixed seed, each compared with bench-computed expectations, cover the flip combinations together with the directed cases.

// File: rtl/tf_pkg.sv
package tf_pkg;
    // Default geometry of the extended nametable entry
    localparam int TF_TILE_W = 12;
    localparam int TF_ATTR_W = 2;
    localparam int TF_ROW_W  = 3;
    localparam int TF_DATA_W = 8;

    // Flip controls decoded from the entry
    typedef struct packed {
        logic vflip;
        logic hflip;
    } tf_flip_t;
endpackage

// File: rtl/tf_entry_reg.sv
module tf_entry_reg #(
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nt_strobe,
    input  logic [ENTRY_W-1:0] nt_word,
    output logic [ENTRY_W-1:0] entry
);
    typedef struct packed {
        logic [ENTRY_W-1:0] entry;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (nt_strobe) begin
            state_d.entry = nt_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign entry = state_q.entry;

    // R2: a strobed word is the held entry one cycle later
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        nt_strobe |=> (entry == $past(nt_word)));

    // R3: without a strobe the held entry does not move
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !nt_strobe |=> $stable(entry));
endmodule

// File: rtl/tf_entry_decode.sv
module tf_entry_decode
    import tf_pkg::*;
#(
    parameter int TILE_W  = TF_TILE_W,
    parameter int ATTR_W  = TF_ATTR_W,
    localparam int ENTRY_W = TILE_W + ATTR_W + 2
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic [TILE_W-1:0]  tile,
    output logic [ATTR_W-1:0]  attr,
    output tf_flip_t           flip
);
    localparam int ATTR_LO = TILE_W;
    localparam int HFLIP_B = TILE_W + ATTR_W;
    localparam int VFLIP_B = HFLIP_B + 1;

    always_comb begin
        tile       = entry[TILE_W-1:0];
        attr       = entry[ATTR_LO +: ATTR_W];
        flip.hflip = entry[HFLIP_B];
        flip.vflip = entry[VFLIP_B];
    end
endmodule

// File: rtl/tf_addr_form.sv
module tf_addr_form #(
    parameter int TILE_W = 12,
    parameter int ROW_W  = 3,
    localparam int LO_W  = ROW_W + 1,
    localparam int MEM_AW = TILE_W + LO_W
) (
    input  logic [TILE_W-1:0] tile,
    input  logic              vflip,
    input  logic [LO_W-1:0]   vid_addr,
    output logic [MEM_AW-1:0] mem_addr
);
    logic [ROW_W-1:0] row;

    // One XOR per row bit; the plane bit bypasses this path entirely
    for (genvar i = 0; i < ROW_W; i++) begin : g_row
        assign row[i] = vid_addr[i] ^ vflip;
    end

    assign mem_addr = {tile, vid_addr[ROW_W], row};
endmodule

// File: rtl/tf_data_flip.sv
module tf_data_flip #(
    parameter int DATA_W = 8
) (
    input  logic              hflip,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] rev;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign rev[i] = din[DATA_W-1-i];
    end

    assign dout = hflip ? rev : din;
endmodule

// File: rtl/tf_flip_unit.sv
module tf_flip_unit
    import tf_pkg::*;
#(
    parameter int TILE_W = TF_TILE_W,
    parameter int ATTR_W = TF_ATTR_W,
    parameter int ROW_W  = TF_ROW_W,
    parameter int DATA_W = TF_DATA_W,
    localparam int ENTRY_W = TILE_W + ATTR_W + 2,
    localparam int LO_W    = ROW_W + 1,
    localparam int MEM_AW  = TILE_W + LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nt_strobe,
    input  logic [ENTRY_W-1:0] nt_word,
    input  logic [LO_W-1:0]    vid_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  vid_rdata,
    output logic [ATTR_W-1:0]  attr
);
    logic [ENTRY_W-1:0] entry;
    logic [TILE_W-1:0]  tile;
    tf_flip_t           flip;

    tf_entry_reg #(.ENTRY_W(ENTRY_W)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .nt_strobe (nt_strobe),
        .nt_word   (nt_word),
        .entry     (entry)
    );

    tf_entry_decode #(.TILE_W(TILE_W), .ATTR_W(ATTR_W)) u_decode (
        .entry (entry),
        .tile  (tile),
        .attr  (attr),
        .flip  (flip)
    );

    tf_addr_form #(.TILE_W(TILE_W), .ROW_W(ROW_W)) u_addr (
        .tile     (tile),
        .vflip    (flip.vflip),
        .vid_addr (vid_addr),
        .mem_addr (mem_addr)
    );

    tf_data_flip #(.DATA_W(DATA_W)) u_data (
        .hflip (flip.hflip),
        .din   (mem_rdata),
        .dout  (vid_rdata)
    );

    // R5: vertical flip mirrors the row bits of the fetch address
    a_r5_row_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        flip.vflip |-> (mem_addr[ROW_W-1:0] == ~vid_addr[ROW_W-1:0]));

    // R7: without vertical flip the row bits pass straight through
    a_r7_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !flip.vflip |-> (mem_addr[ROW_W-1:0] == vid_addr[ROW_W-1:0]));

    // R8: the plane select is never touched
    a_r8_plane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[ROW_W] == vid_addr[ROW_W]);

    // R6: a reversal only reorders bits, so the population stays equal
    a_r6_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vid_rdata) == $countones(mem_rdata));

    // R7: without horizontal flip the byte is returned unchanged
    a_r7_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !flip.hflip |-> (vid_rdata == mem_rdata));

    // R4: the attribute follows the word strobed in the previous cycle
    a_r4_attr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        nt_strobe |=> (attr == $past(nt_word[TILE_W +: ATTR_W])));

    // R2: the tile index reaches the upper address bits after the strobe
    a_r2_tile_follows: assert property (@(posedge clk) disable iff (!rst_n)
        nt_strobe |=> (mem_addr[MEM_AW-1:LO_W] == $past(nt_word[TILE_W-1:0])));
endmodule

// File: tb/tf_flip_unit_tb.sv
module tf_flip_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nt_strobe = 1'b0;
    logic [15:0] nt_word = '0;
    logic [3:0]  vid_addr = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic [7:0]  vid_rdata;
    logic [1:0]  attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tf_flip_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nt_strobe (nt_strobe),
        .nt_word   (nt_word),
        .vid_addr  (vid_addr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .vid_rdata (vid_rdata),
        .attr      (attr)
    );

    function automatic logic [15:0] exp_addr(logic [15:0] e, logic [3:0] lo);
        return {e[11:0], lo[3], lo[2:0] ^ {3{e[15]}}};
    endfunction

    function automatic logic [7:0] exp_data(logic [15:0] e, logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return e[14] ? r : d;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply fetch inputs on a falling edge, then compare all outputs
    task automatic probe(string req, logic [15:0] e, logic [3:0] lo, logic [7:0] d);
        vid_addr  = lo;
        mem_rdata = d;
        #1;
        chk(mem_addr == exp_addr(e, lo), {req, " addr"}, 32'(mem_addr), 32'(exp_addr(e, lo)));
        chk(vid_rdata == exp_data(e, d), {req, " data"}, 32'(vid_rdata), 32'(exp_data(e, d)));
        chk(attr == e[13:12], {req, " attr"}, 32'(attr), 32'(e[13:12]));
    endtask

    task automatic load(logic [15:0] e);
        @(negedge clk);
        nt_strobe = 1'b1;
        nt_word   = e;
        @(negedge clk);
        nt_strobe = 1'b0;
        model     = e;
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd24006);
        repeat (3) @(negedge clk);
        // R1: reset state
        probe("R1", 16'h0000, 4'hB, 8'h35);
        rst_n = 1'b1;
        @(negedge clk);
        probe("R1", 16'h0000, 4'h6, 8'hC1);

        // R2 / R4: capture of tile index and attribute, no flips (R7)
        load(16'h2ABC);
        probe("R2", model, 4'h5, 8'h96);
        probe("R7", model, 4'hA, 8'h3C);

        // R5: vertical flip only, row 0 and row 7 boundaries, both planes (R8)
        load(16'h8123);
        probe("R5", model, 4'h0, 8'h01);
        probe("R5", model, 4'h7, 8'h80);
        probe("R8", model, 4'h8, 8'hF0);
        probe("R8", model, 4'hF, 8'h0F);

        // R6: horizontal flip only
        load(16'h5FFF);
        probe("R6", model, 4'h3, 8'h01);
        probe("R6", model, 4'hC, 8'hB2);

        // R9: both flips together with the largest tile index
        load(16'hFFFF);
        probe("R9", model, 4'h2, 8'hE4);
        probe("R9", model, 4'hD, 8'h17);

        // R3: words on the bus without a strobe are ignored
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            nt_word = 16'(k * 16'h3A5D + 16'h0101);
            probe("R3", model, 4'(k), 8'(8'h5A + k));
        end

        // R10: capture and rewrite in one cycle
        @(negedge clk);
        nt_strobe = 1'b1;
        nt_word   = 16'h4567;
        probe("R10 before edge", model, 4'h1, 8'hC8);
        @(negedge clk);
        nt_strobe = 1'b0;
        model     = 16'h4567;
        probe("R10 after edge", model, 4'h1, 8'hC8);

        // Random mix of strobes, entries, addresses and bytes
        for (int n = 0; n < 300; n++) begin
            logic [15:0] w;
            logic        s;
            w = 16'($urandom());
            s = ($urandom() % 3) == 0;
            @(negedge clk);
            nt_strobe = s;
            nt_word   = w;
            probe(w[15] ? (w[14] ? "R9" : "R5") : (w[14] ? "R6" : "R7"),
                  model, 4'($urandom()), 8'($urandom()));
            if (s) model = w;
        end
        @(negedge clk);
        nt_strobe = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule